// File: doc/BRIEF.md
# Audio Serial Bit-Clock Divider

This block produces the serial bit clock for an audio serial link that runs as master. It also produces an optional master clock output. Both come from one kernel clock. The total division ratio is twice an 8-bit factor, plus one when an odd-extension bit is set, so the divider has to handle odd totals. For an odd total the two halves of the bit clock differ by one kernel cycle, and the longer half is always the one spent away from the resting level.

Configuration arrives on a plain set of input pins. It is copied into shadow registers only while the link is disabled and the divider has fully stopped, so a running clock never changes shape. A factor of 0 or 1 is replaced by 2, and a flag raised by that event stays set until reset. While idle, the bit clock rests at a programmable level, both before enable and after disable. Disabling takes effect only at the end of the current period. A one-cycle strobe in the kernel domain marks every edge that returns the bit clock to its resting level, so that neighbouring shift logic can stay synchronous to the kernel clock.

Top module: `audio_bclk_divider`

## Requirements
- R1: After reset, `sck_o`, `shift_stb_o`, `mclk_o` and `cfg_err_o` are all 0.
- R2: With the odd bit at 0 and a captured factor D, every bit-clock period is 2·D kernel cycles: D cycles away from the resting level, then D cycles at it.
- R3: With the odd bit at 1, the period is 2·D+1 cycles: D+1 cycles away from the resting level, then D cycles at it.
- R4: Configuration inputs are captured only while `enable_i` is 0 and the divider has stopped; changes made while the clock runs or finishes a period have no effect on its timing or its resting level.
- R5: A captured factor of 0 or 1 is treated as 2, and `cfg_err_o` goes to 1 on the cycle after that capture.
- R6: Once `cfg_err_o` is 1 it stays 1 until reset, including after legal factors are captured.
- R7: While stopped, `sck_o` equals the captured resting level (`cfg_idle_hi_i`: 0 rests low, 1 rests high), both before enable and after disable.
- R8: On the first cycle after `enable_i` is sampled high by a stopped divider, `sck_o` leaves the resting level.
- R9: When `enable_i` drops, the current period completes in full: the remaining active half, then a complete resting half. The clock then stays at the resting level with no further strobes. An enable dip that ends before the period ends does not disturb the clock.
- R10: `shift_stb_o` is high for exactly those cycles in which `sck_o` has just returned from the active level to the resting level.
- R11: `mclk_o` toggles on every kernel cycle while `master_i`, the captured master-clock enable and the divider's activity (enabled or finishing) are all true; otherwise it is held at 0.
- R12: No bit-clock level lasts fewer than 2 kernel cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Link enable; sampled at period boundaries while running |
| master_i | input | 1 | Link operates as master; required for master clock output |
| cfg_div_i | input | DIV_W | Linear division factor D |
| cfg_odd_i | input | 1 | Adds one kernel cycle to each period |
| cfg_mclk_en_i | input | 1 | Master clock output enable |
| cfg_idle_hi_i | input | 1 | Resting level of the bit clock |
| sck_o | output | 1 | Serial bit clock |
| shift_stb_o | output | 1 | One-cycle strobe on each return-to-rest edge |
| mclk_o | output | 1 | Master clock, half the kernel rate when gated on |
| cfg_err_o | output | 1 | Sticky flag: an illegal factor was captured |

## Verification
The hardest situation to reach is a configuration change, or an enable dip, that lands while the clock is in the middle of a period. From the ports this looks like an ordinary input wiggle, and it is easy to miss. The stimulus waits until `sck_o` is seen at its active level. It then drops enable for a single cycle, or writes random, even illegal, values onto the configuration pins. A monitor keeps measuring every half-period against the lengths fixed at the start of the test. The same trick is used at shutdown: enable is withdrawn mid-active-half, and the final half and the quiet tail that follows are both measured.

// File: rtl/abd_pkg.sv
package abd_pkg;
   // smallest legal linear factor; smaller values are clamped to it
   localparam int MIN_DIV = 2;

   typedef enum logic {
      PH_ACTIVE = 1'b1,
      PH_REST   = 1'b0
   } phase_e;
endpackage

// File: rtl/abd_cfg_capture.sv
module abd_cfg_capture #(
   parameter int DIV_W   = 8,
   parameter int RST_DIV = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             hold_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             odd_i,
   input  logic             mclk_en_i,
   input  logic             idle_hi_i,
   output logic [DIV_W-1:0] div_o,
   output logic             odd_o,
   output logic             mclk_en_o,
   output logic             idle_hi_o,
   output logic             err_o
);
   localparam logic [DIV_W-1:0] FLOOR = DIV_W'(abd_pkg::MIN_DIV);
   localparam logic [DIV_W-1:0] RSTV  = DIV_W'(RST_DIV);

   logic illegal;
   assign illegal = (div_i < FLOOR);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_o     <= RSTV;
         odd_o     <= 1'b0;
         mclk_en_o <= 1'b0;
         idle_hi_o <= 1'b0;
         err_o     <= 1'b0;
      end else if (!hold_i) begin
         div_o     <= illegal ? FLOOR : div_i;
         odd_o     <= odd_i;
         mclk_en_o <= mclk_en_i;
         idle_hi_o <= idle_hi_i;
         if (illegal) err_o <= 1'b1;
      end
   end
endmodule

// File: rtl/abd_phase_counter.sv
module abd_phase_counter #(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             odd_i,
   input  logic             idle_hi_i,
   output logic             sck_o,
   output logic             stb_o,
   output logic             busy_o
);
   import abd_pkg::*;

   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] act_len, rest_len, cnt_q;
   phase_e           ph_q;

   assign rest_len = {1'b0, div_i};
   assign act_len  = rest_len + CNT_W'(odd_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o <= 1'b0;
         ph_q   <= PH_REST;
         cnt_q  <= '0;
         sck_o  <= 1'b0;
         stb_o  <= 1'b0;
      end else begin
         stb_o <= 1'b0;
         if (!busy_o) begin
            if (en_i) begin
               busy_o <= 1'b1;
               ph_q   <= PH_ACTIVE;
               sck_o  <= ~idle_hi_i;
               cnt_q  <= act_len - 1'b1;
            end else begin
               sck_o <= idle_hi_i;
            end
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (ph_q == PH_ACTIVE) begin
            ph_q  <= PH_REST;
            sck_o <= idle_hi_i;
            stb_o <= 1'b1;
            cnt_q <= rest_len - 1'b1;
         end else if (en_i) begin
            ph_q  <= PH_ACTIVE;
            sck_o <= ~idle_hi_i;
            cnt_q <= act_len - 1'b1;
         end else begin
            busy_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/abd_mclk_gen.sv
module abd_mclk_gen (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic gate_i,
   output logic mclk_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mclk_o <= 1'b0;
      else if (gate_i) mclk_o <= ~mclk_o;
      else             mclk_o <= 1'b0;
   end
endmodule

// File: rtl/audio_bclk_divider.sv
module audio_bclk_divider #(
   parameter int DIV_W   = 8,
   parameter int RST_DIV = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             enable_i,
   input  logic             master_i,
   input  logic [DIV_W-1:0] cfg_div_i,
   input  logic             cfg_odd_i,
   input  logic             cfg_mclk_en_i,
   input  logic             cfg_idle_hi_i,
   output logic             sck_o,
   output logic             shift_stb_o,
   output logic             mclk_o,
   output logic             cfg_err_o
);
   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_width
         $error("DIV_W must lie in 2..16");
      end
      if (RST_DIV < abd_pkg::MIN_DIV || RST_DIV >= (1 << DIV_W)) begin : g_bad_rst
         $error("RST_DIV must be a legal factor");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             odd_q, mclk_en_q, idle_hi_q, busy;

   abd_cfg_capture #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hold_i    (enable_i | busy),
      .div_i     (cfg_div_i),
      .odd_i     (cfg_odd_i),
      .mclk_en_i (cfg_mclk_en_i),
      .idle_hi_i (cfg_idle_hi_i),
      .div_o     (div_q),
      .odd_o     (odd_q),
      .mclk_en_o (mclk_en_q),
      .idle_hi_o (idle_hi_q),
      .err_o     (cfg_err_o)
   );

   abd_phase_counter #(.DIV_W(DIV_W)) u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (enable_i),
      .div_i     (div_q),
      .odd_i     (odd_q),
      .idle_hi_i (idle_hi_q),
      .sck_o     (sck_o),
      .stb_o     (shift_stb_o),
      .busy_o    (busy)
   );

   abd_mclk_gen u_mclk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gate_i (master_i & mclk_en_q & (enable_i | busy)),
      .mclk_o (mclk_o)
   );
endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
   parameter int DIV_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             enable_i,
   input logic             master_i,
   input logic             sck_o,
   input logic             shift_stb_o,
   input logic             mclk_o,
   input logic             cfg_err_o,
   input logic             busy,
   input logic [DIV_W-1:0] div_q,
   input logic             idle_hi_q
);
   p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o |=> cfg_err_o);

   p_div_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_q >= DIV_W'(abd_pkg::MIN_DIV));

   p_cfg_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (enable_i || busy) |=> ($stable(div_q) && $stable(idle_hi_q)));

   p_idle_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy && !enable_i) |=> (sck_o == $past(idle_hi_q)));

   p_start_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy && enable_i) |=> (sck_o != idle_hi_q));

   p_strobe_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_stb_o |-> ((sck_o == idle_hi_q) && (sck_o != $past(sck_o))));

   p_no_runt_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sck_o != $past(sck_o)) |=> (sck_o == $past(sck_o)));

   p_mclk_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !master_i |=> !mclk_o);
endmodule

bind audio_bclk_divider abd_checker #(.DIV_W(DIV_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .enable_i    (enable_i),
   .master_i    (master_i),
   .sck_o       (sck_o),
   .shift_stb_o (shift_stb_o),
   .mclk_o      (mclk_o),
   .cfg_err_o   (cfg_err_o),
   .busy        (busy),
   .div_q       (div_q),
   .idle_hi_q   (idle_hi_q)
);

// File: tb/audio_bclk_divider_tb.sv
module audio_bclk_divider_tb;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          en = 1'b0, master = 1'b0, odd = 1'b0, mclk_en = 1'b0, idle_hi = 1'b0;
   logic [DW-1:0] div = 8'd2;
   logic          sck, stb, mclk, err;

   audio_bclk_divider #(.DIV_W(DW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .master_i(master),
      .cfg_div_i(div), .cfg_odd_i(odd), .cfg_mclk_en_i(mclk_en), .cfg_idle_hi_i(idle_hi),
      .sck_o(sck), .shift_stb_o(stb), .mclk_o(mclk), .cfg_err_o(err));

   int total = 0, bad = 0;
   bit exp_err = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int eff_div(input int d);
      return (d < 2) ? 2 : d;
   endfunction

   // half-period monitor, expectations fixed at test start
   bit mon_on = 0, exp_pol = 0, exp_odd = 0, prev_act = 0, seen_act = 0, en_held = 0;
   logic prev_sck = 0;
   int exp_act = 0, exp_rest = 0, run_len = 0;

   always @(negedge clk) begin
      if (mon_on) begin
         bit is_act;
         is_act = (sck != exp_pol);
         chk(stb == (prev_act && !is_act), "R10", stb, prev_act && !is_act);
         if (sck !== prev_sck) begin
            if (seen_act) chk(run_len >= 2, "R12", run_len, 2);
            if (prev_act)
               chk(run_len == exp_act, exp_odd ? "R3" : "R2", run_len, exp_act);
            else if (seen_act && en_held)
               chk(run_len == exp_rest, "R2", run_len, exp_rest);
            if (is_act) seen_act = 1;
            run_len = 1;
         end else begin
            run_len++;
         end
         prev_sck = sck;
         prev_act = is_act;
      end
   end

   task automatic wait_active();
      do @(negedge clk); while (sck == exp_pol);
   endtask

   task automatic run_case(input int d, input bit o, input bit pol, input bit ms, input bit me);
      int n;
      bit gate;
      @(negedge clk);
      div = d[DW-1:0]; odd = o; idle_hi = pol; master = ms; mclk_en = me;
      if (d < 2) exp_err = 1'b1;
      repeat (3) @(negedge clk);
      chk(sck == pol, "R7", sck, pol);
      chk(err == exp_err, exp_err ? "R5" : "R6", err, exp_err);
      exp_pol = pol; exp_odd = o;
      exp_rest = eff_div(d); exp_act = eff_div(d) + o;
      n = exp_act + exp_rest;
      prev_sck = sck; prev_act = 0; seen_act = 0; run_len = 0; en_held = 1;
      mon_on = 1;
      en = 1'b1;
      @(negedge clk);
      chk(sck == !pol, "R8", sck, !pol);
      repeat (2 * n) @(negedge clk);
      // scramble configuration pins while running
      div = $urandom_range(0, 255); odd = ~o; idle_hi = ~pol; mclk_en = ~me;
      gate = ms && me;
      for (int i = 0; i < 6; i++) begin
         logic m0;
         m0 = mclk;
         @(negedge clk);
         if (gate) chk(mclk != m0, "R11", mclk, !m0);
         else      chk(mclk == 1'b0, "R11", mclk, 0);
      end
      // enable dip inside a period
      wait_active();
      en = 1'b0;
      @(negedge clk);
      en = 1'b1;
      repeat (2 * n) @(negedge clk);
      chk(err == exp_err, "R4", err, exp_err);
      // restore legal pins, then disable mid-active-half
      div = d[DW-1:0]; odd = o; idle_hi = pol; mclk_en = me;
      wait_active();
      en = 1'b0; en_held = 0;
      repeat (n + 4) @(negedge clk);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk(sck == pol && stb == 1'b0, "R9", sck, pol);
         chk(mclk == 1'b0, "R11", mclk, 0);
      end
      mon_on = 0;
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(sck == 1'b0, "R1", sck, 0);
      chk(stb == 1'b0, "R1", stb, 0);
      chk(mclk == 1'b0, "R1", mclk, 0);
      chk(err == 1'b0, "R1", err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sck == 1'b0 && err == 1'b0, "R1", sck, 0);
      run_case(2, 0, 0, 1, 1);
      run_case(2, 1, 1, 1, 0);
      run_case(3, 1, 0, 0, 1);
      run_case(255, 1, 1, 1, 1);
      run_case(7, 0, 1, 1, 1);
      chk(err == 1'b0, "R6", err, 0);
      run_case(0, 1, 0, 1, 1);
      run_case(1, 0, 1, 0, 0);
      run_case(9, 1, 0, 1, 1);
      chk(err == 1'b1, "R6", err, 1);
      for (int k = 0; k < 12; k++)
         run_case($urandom_range(2, 40), $urandom_range(0, 1), $urandom_range(0, 1),
                  $urandom_range(0, 1), $urandom_range(0, 1));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule